// File: doc/BRIEF.md
# Dual-Copy Integer Register File with Lagged Cross-Cluster Writes

This block holds the integer physical registers of a machine whose execution resources are split into two clusters. It keeps two full copies of the register contents, one beside each cluster, so that each copy only needs read ports for its own cluster's arithmetic unit and load/store unit. Every result is written into the copy of the cluster that produced it at once. The same result is forwarded to the other copy through a one-cycle transfer stage.

Because of that transfer stage, a value can sit in one copy while the other copy still holds the old contents. The block reports this in two ways. A per-entry visibility vector goes low for the one cycle in which an entry's newest value has not reached both copies. A per-read ready flag goes low when a cluster reads an entry whose newest value was produced by the other cluster and has not arrived yet. An issue stage uses these signals to hold back dependent work on the far cluster.

Index 31 is a constant zero with no storage behind it.

Top module: `clustered_regfile`

## Requirements
- R1: After reset every entry reads as zero from both clusters, every bit of `vis` is 1 and every `rd_rdy` is 1.
- R2: A value written by a cluster in cycle t is returned from that cluster's copy from cycle t+1 onward, until the entry is written again.
- R3: A read in a cluster that targets an entry being written by the same cluster in the same cycle returns the incoming data, with `rd_rdy` at 1.
- R4: A value written by cluster A in cycle t is returned by cluster B's copy from cycle t+2 onward. During cycle t+1, a read of that entry from B returns the previous contents with `rd_rdy` at 0, unless B itself writes the entry in t+1.
- R5: After a write to entry e in cycle t, `vis[e]` is 0 during cycle t+1. It returns to 1 in cycle t+2 unless e is written again in t+1.
- R6: Index 31 always reads as zero with `rd_rdy` at 1, writes to it are discarded, and `vis[31]` stays 1.
- R7: During the transfer cycle t+1, a read of the entry from the producing cluster has `rd_rdy` at 1 and returns the new value.
- R8: When a transferred write and a local write reach the same copy and entry in the same cycle, the local one (the younger) is kept, so both copies converge on the younger value.
- R9: No two write ports of the whole block target the same entry other than 31 in one cycle. With four distinct targets, all four values land in both copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 2x2 | Write enable, [cluster][port] |
| wr_idx | input | 2x2x7 | Write entry index, [cluster][port] |
| wr_dat | input | 2x2x64 | Write data, [cluster][port] |
| rd_idx | input | 2x4x7 | Read index, [cluster][port]. Ports 0 and 1 serve the arithmetic unit, ports 2 and 3 the load/store unit |
| rd_dat | output | 2x4x64 | Read data, combinational from the index |
| rd_rdy | output | 2x4 | 0 when the read returns data that is stale because the other cluster's write is still in transfer |
| vis | output | 80 | Per entry: 1 when both copies hold the newest value |

## Verification
The hardest situation to reach is the stale remote read. It needs the other cluster to have written the entry exactly one cycle earlier, and the reading cluster must not be writing the entry itself in that cycle. The random stimulus therefore points half of all reads at the entries written in the previous cycle, and draws write targets from a narrow pool so that back-to-back writes to one entry from both clusters happen often. A directed sequence forces the case where a transferred write and a younger local write meet in the same copy and the same cycle.

// File: rtl/crf_pkg.sv
package crf_pkg;
    localparam int CRF_ENTRIES = 80;
    localparam int CRF_W       = 64;
    localparam int CRF_NCL     = 2;
    localparam int CRF_NWP     = 2;
    localparam int CRF_NRD     = 4;
    localparam int CRF_ZIDX    = 31;
endpackage

// File: rtl/crf_copy.sv
// One full copy of the register contents, local to one cluster.
module crf_copy #(
    parameter int ENTRIES = 80,
    parameter int W       = 64,
    parameter int AW      = 7,
    parameter int NWP     = 2,
    parameter int NRD     = 4,
    parameter int ZIDX    = 31
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NWP-1:0]           loc_en,
    input  logic [NWP-1:0][AW-1:0]   loc_idx,
    input  logic [NWP-1:0][W-1:0]    loc_dat,
    input  logic [NWP-1:0]           rem_en,
    input  logic [NWP-1:0][AW-1:0]   rem_idx,
    input  logic [NWP-1:0][W-1:0]    rem_dat,
    input  logic [NRD-1:0][AW-1:0]   rd_idx,
    output logic [NRD-1:0][W-1:0]    rd_dat,
    output logic [NRD-1:0]           rd_byp
);
    typedef struct packed {
        logic [ENTRIES-1:0][W-1:0] mem;
    } copy_st_t;

    copy_st_t st_d, st_q;

    function automatic logic live(input logic [AW-1:0] i);
        return (int'(i) != ZIDX) && (int'(i) < ENTRIES);
    endfunction

    always_comb begin
        st_d = st_q;
        // transferred writes first, so a younger local write wins
        for (int k = 0; k < NWP; k++) begin
            if (rem_en[k] && live(rem_idx[k])) st_d.mem[rem_idx[k]] = rem_dat[k];
        end
        for (int k = 0; k < NWP; k++) begin
            if (loc_en[k] && live(loc_idx[k])) st_d.mem[loc_idx[k]] = loc_dat[k];
        end
    end

    always_comb begin
        for (int p = 0; p < NRD; p++) begin
            rd_dat[p] = '0;
            rd_byp[p] = 1'b0;
            if (live(rd_idx[p])) begin
                rd_dat[p] = st_q.mem[rd_idx[p]];
                for (int k = 0; k < NWP; k++) begin
                    if (loc_en[k] && loc_idx[k] == rd_idx[p]) begin
                        rd_dat[p] = loc_dat[k];
                        rd_byp[p] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/crf_track.sv
// Transfer stage between the copies plus per-entry pending status.
module crf_track #(
    parameter int ENTRIES = 80,
    parameter int W       = 64,
    parameter int AW      = 7,
    parameter int NCL     = 2,
    parameter int NWP     = 2,
    parameter int ZIDX    = 31,
    parameter int CW      = 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NCL-1:0][NWP-1:0]           wr_en,
    input  logic [NCL-1:0][NWP-1:0][AW-1:0]   wr_idx,
    input  logic [NCL-1:0][NWP-1:0][W-1:0]    wr_dat,
    output logic [NCL-1:0][NWP-1:0]           dly_en,
    output logic [NCL-1:0][NWP-1:0][AW-1:0]   dly_idx,
    output logic [NCL-1:0][NWP-1:0][W-1:0]    dly_dat,
    output logic [ENTRIES-1:0]                pend,
    output logic [ENTRIES-1:0][CW-1:0]        src
);
    typedef struct packed {
        logic [NCL-1:0][NWP-1:0]         en;
        logic [NCL-1:0][NWP-1:0][AW-1:0] idx;
        logic [NCL-1:0][NWP-1:0][W-1:0]  dat;
        logic [ENTRIES-1:0]              pend;
        logic [ENTRIES-1:0][CW-1:0]      src;
    } trk_st_t;

    trk_st_t st_d, st_q;

    function automatic logic live(input logic [AW-1:0] i);
        return (int'(i) != ZIDX) && (int'(i) < ENTRIES);
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.pend = '0;
        for (int c = 0; c < NCL; c++) begin
            for (int k = 0; k < NWP; k++) begin
                st_d.en[c][k]  = wr_en[c][k] && live(wr_idx[c][k]);
                st_d.idx[c][k] = wr_idx[c][k];
                st_d.dat[c][k] = wr_dat[c][k];
                if (wr_en[c][k] && live(wr_idx[c][k])) begin
                    st_d.pend[wr_idx[c][k]] = 1'b1;
                    st_d.src[wr_idx[c][k]]  = CW'(c);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dly_en  = st_q.en;
    assign dly_idx = st_q.idx;
    assign dly_dat = st_q.dat;
    assign pend    = st_q.pend;
    assign src     = st_q.src;
endmodule

// File: rtl/clustered_regfile.sv
module clustered_regfile
    import crf_pkg::*;
#(
    parameter int ENTRIES = CRF_ENTRIES,
    parameter int W       = CRF_W,
    parameter int NWP     = CRF_NWP,
    parameter int NRD     = CRF_NRD,
    parameter int ZIDX    = CRF_ZIDX,
    localparam int AW     = $clog2(ENTRIES),
    localparam int NCL    = CRF_NCL,
    localparam int CW     = 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NCL-1:0][NWP-1:0]           wr_en,
    input  logic [NCL-1:0][NWP-1:0][AW-1:0]   wr_idx,
    input  logic [NCL-1:0][NWP-1:0][W-1:0]    wr_dat,
    input  logic [NCL-1:0][NRD-1:0][AW-1:0]   rd_idx,
    output logic [NCL-1:0][NRD-1:0][W-1:0]    rd_dat,
    output logic [NCL-1:0][NRD-1:0]           rd_rdy,
    output logic [ENTRIES-1:0]                vis
);
    logic [NCL-1:0][NWP-1:0]         dly_en;
    logic [NCL-1:0][NWP-1:0][AW-1:0] dly_idx;
    logic [NCL-1:0][NWP-1:0][W-1:0]  dly_dat;
    logic [ENTRIES-1:0]              pend;
    logic [ENTRIES-1:0][CW-1:0]      src;
    logic [NCL-1:0][NRD-1:0]         byp;

    crf_track #(
        .ENTRIES(ENTRIES), .W(W), .AW(AW), .NCL(NCL),
        .NWP(NWP), .ZIDX(ZIDX), .CW(CW)
    ) u_track (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_dat(wr_dat),
        .dly_en(dly_en), .dly_idx(dly_idx), .dly_dat(dly_dat),
        .pend(pend), .src(src)
    );

    // copy c takes local writes from cluster c and delayed ones from the other
    for (genvar c = 0; c < NCL; c++) begin : g_copy
        crf_copy #(
            .ENTRIES(ENTRIES), .W(W), .AW(AW),
            .NWP(NWP), .NRD(NRD), .ZIDX(ZIDX)
        ) u_copy (
            .clk(clk), .rst_n(rst_n),
            .loc_en(wr_en[c]), .loc_idx(wr_idx[c]), .loc_dat(wr_dat[c]),
            .rem_en(dly_en[1-c]), .rem_idx(dly_idx[1-c]), .rem_dat(dly_dat[1-c]),
            .rd_idx(rd_idx[c]), .rd_dat(rd_dat[c]), .rd_byp(byp[c])
        );
    end

    always_comb begin
        for (int c = 0; c < NCL; c++) begin
            for (int p = 0; p < NRD; p++) begin
                rd_rdy[c][p] = 1'b1;
                if ((int'(rd_idx[c][p]) != ZIDX) && (int'(rd_idx[c][p]) < ENTRIES) &&
                    !byp[c][p] && pend[rd_idx[c][p]] &&
                    (src[rd_idx[c][p]] != CW'(c)))
                    rd_rdy[c][p] = 1'b0;
            end
        end
    end

    assign vis = ~pend;
endmodule

// File: rtl/crf_chk.sv
module crf_chk #(
    parameter int ENTRIES = 80,
    parameter int W       = 64,
    parameter int NWP     = 2,
    parameter int NRD     = 4,
    parameter int ZIDX    = 31,
    localparam int AW     = $clog2(ENTRIES),
    localparam int NCL    = 2
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [NCL-1:0][NWP-1:0]           wr_en,
    input logic [NCL-1:0][NWP-1:0][AW-1:0]   wr_idx,
    input logic [NCL-1:0][NWP-1:0][W-1:0]    wr_dat,
    input logic [NCL-1:0][NRD-1:0][AW-1:0]   rd_idx,
    input logic [NCL-1:0][NRD-1:0][W-1:0]    rd_dat,
    input logic [NCL-1:0][NRD-1:0]           rd_rdy,
    input logic [ENTRIES-1:0]                vis
);
    logic [NCL-1:0][NRD-1:0] loc_hit;

    always_comb begin
        for (int c = 0; c < NCL; c++)
            for (int p = 0; p < NRD; p++) begin
                loc_hit[c][p] = 1'b0;
                for (int k = 0; k < NWP; k++)
                    if (wr_en[c][k] && wr_idx[c][k] == rd_idx[c][p]) loc_hit[c][p] = 1'b1;
            end
    end

    p_reset_vis_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&vis));

    p_zero_vis_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vis[ZIDX]);

    for (genvar c = 0; c < NCL; c++) begin : g_c
        for (genvar p = 0; p < NRD; p++) begin : g_p
            p_zero_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(rd_idx[c][p]) == ZIDX) |-> (rd_dat[c][p] == '0 && rd_rdy[c][p]));
            for (genvar k = 0; k < NWP; k++) begin : g_k
                p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    (wr_en[c][k] && wr_idx[c][k] == rd_idx[c][p] &&
                     int'(rd_idx[c][p]) != ZIDX && int'(rd_idx[c][p]) < ENTRIES)
                    |-> (rd_dat[c][p] == wr_dat[c][k] && rd_rdy[c][p]));
                p_remote_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
                    ($past(wr_en[1-c][k]) && rd_idx[c][p] == $past(wr_idx[1-c][k]) &&
                     int'(rd_idx[c][p]) != ZIDX && int'(rd_idx[c][p]) < ENTRIES &&
                     !loc_hit[c][p]) |-> !rd_rdy[c][p]);
            end
        end
        for (genvar k = 0; k < NWP; k++) begin : g_w
            p_vis_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en[c][k] && int'(wr_idx[c][k]) != ZIDX && int'(wr_idx[c][k]) < ENTRIES)
                |=> !vis[$past(wr_idx[c][k])]);
        end
    end

    for (genvar a = 0; a < NCL*NWP; a++) begin : g_a
        for (genvar b = a + 1; b < NCL*NWP; b++) begin : g_b
            p_unique_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en[a/NWP][a%NWP] && wr_en[b/NWP][b%NWP] &&
                 int'(wr_idx[a/NWP][a%NWP]) != ZIDX)
                |-> (wr_idx[a/NWP][a%NWP] != wr_idx[b/NWP][b%NWP]));
        end
    end
endmodule

bind clustered_regfile crf_chk #(
    .ENTRIES(ENTRIES), .W(W), .NWP(NWP), .NRD(NRD), .ZIDX(ZIDX)
) u_chk (.*);

// File: tb/tb_clustered_regfile.sv
`timescale 1ns/1ps
module tb_clustered_regfile;
    localparam int E = 80;
    localparam int W = 64;
    localparam int AW = 7;
    localparam int NC = 2;
    localparam int NP = 2;
    localparam int NR = 4;
    localparam int Z = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0][NP-1:0]         wr_en;
    logic [NC-1:0][NP-1:0][AW-1:0] wr_idx;
    logic [NC-1:0][NP-1:0][W-1:0]  wr_dat;
    logic [NC-1:0][NR-1:0][AW-1:0] rd_idx;
    logic [NC-1:0][NR-1:0][W-1:0]  rd_dat;
    logic [NC-1:0][NR-1:0]         rd_rdy;
    logic [E-1:0]                  vis;

    clustered_regfile dut (.*);

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // reference state
    logic [W-1:0] ref_mem [NC][E];
    bit           ref_pend [E];
    int           ref_src [E];
    bit           d_en [NC][NP];
    int           d_idx [NC][NP];
    logic [W-1:0] d_dat [NC][NP];

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit live(int i);
        return (i != Z) && (i < E);
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NC; c++) begin
            for (int e = 0; e < E; e++) ref_mem[c][e] = '0;
            for (int k = 0; k < NP; k++) begin d_en[c][k] = 0; d_idx[c][k] = 0; d_dat[c][k] = '0; end
        end
        for (int e = 0; e < E; e++) begin ref_pend[e] = 0; ref_src[e] = 0; end
    endtask

    // expected outputs for the current inputs and model state
    task automatic check_outputs();
        logic [E-1:0] exp_vis;
        for (int c = 0; c < NC; c++) begin
            for (int p = 0; p < NR; p++) begin
                int i;
                logic [W-1:0] ed;
                logic er;
                bit hit;
                string tg;
                i = int'(rd_idx[c][p]);
                hit = 0;
                ed = '0; er = 1'b1;
                if (i == Z) tg = "R6";
                else begin
                    ed = ref_mem[c][i];
                    for (int k = 0; k < NP; k++)
                        if (wr_en[c][k] && int'(wr_idx[c][k]) == i) begin hit = 1; ed = wr_dat[c][k]; end
                    if (hit) tg = "R3";
                    else if (ref_pend[i] && ref_src[i] != c) begin tg = "R4"; er = 1'b0; end
                    else if (ref_pend[i]) tg = "R7";
                    else tg = "R2";
                end
                chk(tg, $sformatf("rd_dat[%0d][%0d] idx %0d", c, p, i), rd_dat[c][p], ed);
                chk(tg, $sformatf("rd_rdy[%0d][%0d] idx %0d", c, p, i), W'(rd_rdy[c][p]), W'(er));
            end
        end
        for (int e = 0; e < E; e++) exp_vis[e] = !ref_pend[e];
        chk("R5", "vis low part", W'(vis[63:0]), W'(exp_vis[63:0]));
        chk("R5", "vis high part", W'(vis[E-1:64]), W'(exp_vis[E-1:64]));
    endtask

    task automatic model_update();
        for (int c = 0; c < NC; c++) begin
            for (int k = 0; k < NP; k++)
                if (d_en[1-c][k] && live(d_idx[1-c][k])) ref_mem[c][d_idx[1-c][k]] = d_dat[1-c][k];
            for (int k = 0; k < NP; k++)
                if (wr_en[c][k] && live(int'(wr_idx[c][k]))) ref_mem[c][wr_idx[c][k]] = wr_dat[c][k];
        end
        for (int e = 0; e < E; e++) ref_pend[e] = 0;
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < NP; k++) begin
                d_en[c][k] = wr_en[c][k]; d_idx[c][k] = int'(wr_idx[c][k]); d_dat[c][k] = wr_dat[c][k];
                if (wr_en[c][k] && live(int'(wr_idx[c][k]))) begin
                    ref_pend[wr_idx[c][k]] = 1; ref_src[wr_idx[c][k]] = c;
                end
            end
    endtask

    // called right after inputs are driven at a falling edge
    task automatic step();
        #2;
        check_outputs();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = '0;
    endtask

    task automatic rand_cycle();
        int used [4];
        int n;
        n = 0;
        // R9: targets other than 31 are kept distinct across all write ports
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < NP; k++) begin
                int t;
                bit ok;
                wr_en[c][k] = 1'($urandom_range(0, 1));
                wr_dat[c][k] = {$urandom, $urandom};
                do begin
                    t = ($urandom_range(0, 3) == 0) ? $urandom_range(0, E - 1) : $urandom_range(28, 39);
                    ok = 1;
                    for (int j = 0; j < n; j++) if (used[j] == t && t != Z) ok = 0;
                end while (!ok);
                wr_idx[c][k] = AW'(t);
                if (wr_en[c][k]) begin used[n] = t; n++; end
            end
        for (int c = 0; c < NC; c++)
            for (int p = 0; p < NR; p++) begin
                if ($urandom_range(0, 1) == 1) begin
                    int cc = $urandom_range(0, NC - 1);
                    int kk = $urandom_range(0, NP - 1);
                    rd_idx[c][p] = AW'(d_idx[cc][kk]);
                end else rd_idx[c][p] = AW'($urandom_range(0, E - 1));
            end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        wr_en = '0; wr_idx = '0; wr_dat = '0; rd_idx = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents
        for (int c = 0; c < NC; c++)
            for (int p = 0; p < NR; p++) rd_idx[c][p] = AW'(p * 17 + c * 5);
        #2;
        chk("R1", "vis after reset", W'(&vis), W'(1));
        for (int c = 0; c < NC; c++)
            for (int p = 0; p < NR; p++) begin
                chk("R1", "rd_dat after reset", rd_dat[c][p], '0);
                chk("R1", "rd_rdy after reset", W'(rd_rdy[c][p]), W'(1));
            end
        @(negedge clk);

        // R2/R4/R5/R7: cluster 0 writes entry 5, both clusters read it
        wr_en[0][0] = 1'b1; wr_idx[0][0] = 7'd5; wr_dat[0][0] = 64'hA5A5_0000_1111_0005;
        rd_idx[0][0] = 7'd5; rd_idx[1][0] = 7'd5;
        step();
        idle();
        step();   // cycle t+1: remote stale, R4 and R7 checked by model
        step();   // cycle t+2: both copies hold it

        // R6: write to index 31 is discarded
        wr_en[1][1] = 1'b1; wr_idx[1][1] = 7'd31; wr_dat[1][1] = '1;
        rd_idx[1][1] = 7'd31; rd_idx[0][1] = 7'd31;
        step();
        idle();
        step();
        chk("R6", "vis[31] after write to 31", W'(vis[Z]), W'(1));
        chk("R6", "read 31 after write", rd_dat[0][1], '0);

        // R8: transferred write meets younger local write in copy 1
        wr_en[0][0] = 1'b1; wr_idx[0][0] = 7'd40; wr_dat[0][0] = 64'h1111;
        step();
        wr_en = '0;
        wr_en[1][1] = 1'b1; wr_idx[1][1] = 7'd40; wr_dat[1][1] = 64'h2222;
        step();
        idle();
        step();
        rd_idx[0][2] = 7'd40; rd_idx[1][3] = 7'd40;
        step();
        chk("R8", "copy0 entry 40", rd_dat[0][2], 64'h2222);
        chk("R8", "copy1 entry 40", rd_dat[1][3], 64'h2222);

        // R9: four distinct simultaneous writes
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < NP; k++) begin
                wr_en[c][k] = 1'b1; wr_idx[c][k] = AW'(10 + c * 2 + k); wr_dat[c][k] = W'(64'hC0DE00 + c * 2 + k);
            end
        step();
        idle();
        step();
        for (int c = 0; c < NC; c++)
            for (int p = 0; p < NR; p++) rd_idx[c][p] = AW'(10 + p);
        step();
        for (int c = 0; c < NC; c++)
            for (int p = 0; p < NR; p++)
                chk("R9", $sformatf("copy%0d entry %0d", c, 10 + p), rd_dat[c][p], W'(64'hC0DE00 + p));

        // random phase
        for (int n = 0; n < 3000; n++) begin
            rand_cycle();
            step();
        end

        // final sweep of both copies against the model
        idle();
        step();
        step();
        for (int base = 0; base < E; base += NR) begin
            for (int c = 0; c < NC; c++)
                for (int p = 0; p < NR; p++) rd_idx[c][p] = AW'(base + p);
            step();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule